// File: doc/BRIEF.md
# Multi-Stream Monitor Slot Serializer

This block puts up to six monitor words onto one shared serial data line of a time-division-multiplexed audio bus. The six streams are voltage sense, current sense, two supply readings, die temperature and a status byte. The line is divided into 8-bit slots, and every stream has an enable and a 6-bit start slot. A 16-bit word fills two neighbouring slots. The block runs on the bit clock. A rising edge on the frame sync input starts a frame.

Configuration selects several things:
- the bit-clock edge on which data is launched;
- a small offset from frame start to slot 0;
- whether bits that no stream owns are driven low or released;
- the width sent for the two sense streams;
- how a weak bus keeper is requested when the line is released.

All six stream values are captured when a frame starts, so each frame carries one consistent set of readings.

Top module: `tdm_mon_tx`

## Requirements
- R1: A frame starts at the first bit clock where `fsync` is sampled high after being low. That bit clock is frame position 0. Slot n starts at position `tx_offset` + 8·n, where offset 0 gives left-justified timing and offset 1 gives I2S timing.
- R2: With `tx_fall`=0, the line changes after rising clock edges. With `tx_fall`=1, it carries the same bit sequence but changes after falling edges, half a clock later.
- R3: Bits go out MSB first. In 16-bit sense mode (`sense_mode` 0 or 3), a sense word sends its upper byte in its start slot and its lower byte in the next slot. Supply words always take 16 bits. Temperature and status take 8 bits each.
- R4: With `sense_mode`=1, only the upper 8 bits of each sense word are sent, in its start slot.
- R5: With `sense_mode`=2, each sense stream sends its upper 12 bits. When both sense streams are enabled and one starts exactly one slot after the other, the later one begins 4 bits into its slot. The two words then fill three consecutive slots back to back.
- R6: A bit that no enabled stream owns goes out as a driven 0 when `fill_hiz`=0, and is released (`sd_oe`=0, `sd_out`=0) when `fill_hiz`=1.
- R7: When enabled streams overlap, the owning stream is chosen by a fixed order, highest first: voltage sense, current sense, supply 1, supply 2, temperature, status.
- R8: Stream values are captured when the frame starts. Changes during the frame do not affect it.
- R9: A new frame start cuts off any stream still being sent and restarts at position 0. A stream with no new frame start ends after its own last bit.
- R10: With `keep_on`=0, `keep_en` stays low in every mode.
- R11: With the keeper on, `keep_always`=0 and `fill_hiz`=1, `keep_en` is high for exactly one bit period after a driven bit that is followed by a released bit.
- R12: With the keeper on and `keep_always`=1, `keep_en` is high whenever `sd_oe` is low.
- R13: With `keep_half`=1, a driven bit followed by a released bit is driven only for the first half of its period. `sd_oe` drops at the opposite clock edge, and `keep_en` covers that second half when the keeper is on.
- R14: During and after reset, until the first frame start, no stream bit is sent. While reset is held, `sd_out`=0 and `sd_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync; a rising edge starts a frame |
| tx_fall | input | 1 | 1: launch on the falling edge, 0: launch on the rising edge |
| tx_offset | input | 3 | Bit clocks from frame start to slot 0 |
| fill_hiz | input | 1 | 1: release unowned bits, 0: drive them low |
| sense_mode | input | 2 | Sense width: 0/3 = 16 bits, 1 = 8 bits, 2 = packed 12 bits |
| keep_on | input | 1 | Keeper request enable |
| keep_always | input | 1 | 1: keep whenever released, 0: one bit after the last driven bit |
| keep_half | input | 1 | Drive the last bit before a release for half a period |
| vs_en | input | 1 | Voltage sense enable |
| vs_slot | input | 6 | Voltage sense start slot |
| vs_val | input | 16 | Voltage sense value |
| is_en | input | 1 | Current sense enable |
| is_slot | input | 6 | Current sense start slot |
| is_val | input | 16 | Current sense value |
| s1_en | input | 1 | Supply 1 enable |
| s1_slot | input | 6 | Supply 1 start slot |
| s1_val | input | 16 | Supply 1 value |
| s2_en | input | 1 | Supply 2 enable |
| s2_slot | input | 6 | Supply 2 start slot |
| s2_val | input | 16 | Supply 2 value |
| tp_en | input | 1 | Temperature enable |
| tp_slot | input | 6 | Temperature start slot |
| tp_val | input | 8 | Temperature value |
| st_en | input | 1 | Status enable |
| st_slot | input | 6 | Status start slot |
| st_val | input | 8 | Status value |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Data output enable |
| keep_en | output | 1 | Weak bus keeper request |

## Verification
The assertions check on every clock edge that:
- no keeper request appears while the keeper is off;
- a driven-low fill keeps the output enabled;
- in one-bit keeper mode, a keeper request never lasts two bit clocks;
- nothing is sent before the first frame start.

Slot placement, the offset, both launch edges, the packed 12-bit layout, overlap priority, the frame-start capture and cutting at a new frame depend on stream contents and configuration. Only the bench's scenarios show these. Its reference model builds the whole frame bit map on its own and compares the line in both halves of every clock.

// File: rtl/tdm_mon_tx.sv
module tdm_mon_tx #(
  parameter int SLOT_SEL_W = 6,
  parameter int OFS_W      = 3,
  parameter int WIDE_W     = 16,
  parameter int BYTE_W     = 8,
  parameter int PACK_W     = 12,
  parameter int POS_W      = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsync,
  input  logic                  tx_fall,
  input  logic [OFS_W-1:0]      tx_offset,
  input  logic                  fill_hiz,
  input  logic [1:0]            sense_mode,
  input  logic                  keep_on,
  input  logic                  keep_always,
  input  logic                  keep_half,
  input  logic                  vs_en,
  input  logic [SLOT_SEL_W-1:0] vs_slot,
  input  logic [WIDE_W-1:0]     vs_val,
  input  logic                  is_en,
  input  logic [SLOT_SEL_W-1:0] is_slot,
  input  logic [WIDE_W-1:0]     is_val,
  input  logic                  s1_en,
  input  logic [SLOT_SEL_W-1:0] s1_slot,
  input  logic [WIDE_W-1:0]     s1_val,
  input  logic                  s2_en,
  input  logic [SLOT_SEL_W-1:0] s2_slot,
  input  logic [WIDE_W-1:0]     s2_val,
  input  logic                  tp_en,
  input  logic [SLOT_SEL_W-1:0] tp_slot,
  input  logic [BYTE_W-1:0]     tp_val,
  input  logic                  st_en,
  input  logic [SLOT_SEL_W-1:0] st_slot,
  input  logic [BYTE_W-1:0]     st_val,
  output logic                  sd_out,
  output logic                  sd_oe,
  output logic                  keep_en
);
  localparam int NSTR       = 6;
  localparam int CW         = POS_W + 1;
  localparam int IDX_W      = $clog2(WIDE_W);
  localparam int SU_LG      = $clog2(BYTE_W);
  localparam int PACK_SHIFT = PACK_W - BYTE_W;
  localparam logic [POS_W-1:0] POS_IDLE = '1;

  logic             fs_q;
  logic [POS_W-1:0] cnt;
  logic [POS_W-1:0] pos_cur;
  logic             fs_start;
  logic [CW-1:0]    pc;
  logic [CW-1:0]    pn;

  assign fs_start = fsync & ~fs_q;
  assign pos_cur  = fs_start ? '0 : ((cnt == POS_IDLE) ? cnt : cnt + 1'b1);
  assign pc       = {1'b0, pos_cur};
  assign pn       = pc + 1'b1;

  logic [WIDE_W-1:0]     live [NSTR];
  logic [WIDE_W-1:0]     snap [NSTR];
  logic [WIDE_W-1:0]     src  [NSTR];
  logic [SLOT_SEL_W-1:0] slot [NSTR];
  logic [IDX_W:0]        len  [NSTR];
  logic [NSTR-1:0]       en;
  logic [IDX_W:0]        sense_len;
  logic                  vs_up, is_up;

  assign live[0] = vs_val;
  assign live[1] = is_val;
  assign live[2] = s1_val;
  assign live[3] = s2_val;
  assign live[4] = {tp_val, {(WIDE_W-BYTE_W){1'b0}}};
  assign live[5] = {st_val, {(WIDE_W-BYTE_W){1'b0}}};

  assign slot[0] = vs_slot;
  assign slot[1] = is_slot;
  assign slot[2] = s1_slot;
  assign slot[3] = s2_slot;
  assign slot[4] = tp_slot;
  assign slot[5] = st_slot;

  assign en = {st_en, tp_en, s2_en, s1_en, is_en, vs_en};

  always_comb begin
    case (sense_mode)
      2'd1:    sense_len = (IDX_W+1)'(BYTE_W);
      2'd2:    sense_len = (IDX_W+1)'(PACK_W);
      default: sense_len = (IDX_W+1)'(WIDE_W);
    endcase
  end

  assign len[0] = sense_len;
  assign len[1] = sense_len;
  assign len[2] = (IDX_W+1)'(WIDE_W);
  assign len[3] = (IDX_W+1)'(WIDE_W);
  assign len[4] = (IDX_W+1)'(BYTE_W);
  assign len[5] = (IDX_W+1)'(BYTE_W);

  assign vs_up = (sense_mode == 2'd2) && is_en &&
                 ({1'b0, vs_slot} == ({1'b0, is_slot} + 1'b1));
  assign is_up = (sense_mode == 2'd2) && vs_en &&
                 ({1'b0, is_slot} == ({1'b0, vs_slot} + 1'b1));

  logic [NSTR-1:0] hit_c, bit_c, hit_n;

  for (genvar g = 0; g < NSTR; g++) begin : g_str
    logic [CW-1:0]    base, stop;
    logic [IDX_W-1:0] off_c;
    logic             up;
    assign up        = (g == 0) ? vs_up : ((g == 1) ? is_up : 1'b0);
    assign src[g]    = fs_start ? live[g] : snap[g];
    assign base      = (CW'(slot[g]) << SU_LG) + CW'(tx_offset) +
                       (up ? CW'(PACK_SHIFT) : '0);
    assign stop      = base + CW'(len[g]);
    assign off_c     = IDX_W'(pc - base);
    assign hit_c[g]  = en[g] && (pc >= base) && (pc < stop);
    assign hit_n[g]  = en[g] && (pn >= base) && (pn < stop);
    assign bit_c[g]  = src[g][IDX_W'(WIDE_W-1) - off_c];
  end

  logic own_c, dat_c, own_n;

  always_comb begin
    own_c = 1'b0;
    dat_c = 1'b0;
    for (int i = NSTR-1; i >= 0; i--) begin
      if (hit_c[i]) begin
        own_c = 1'b1;
        dat_c = bit_c[i];
      end
    end
  end

  assign own_n = |hit_n;

  logic a_d, a_oe, a_last, a_hold;
  logic b_d, b_oe, b_last, b_hold;
  logic c_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      cnt    <= POS_IDLE;
      a_d    <= 1'b0;
      a_oe   <= 1'b0;
      a_last <= 1'b0;
      a_hold <= 1'b0;
      c_last <= 1'b0;
    end else begin
      fs_q   <= fsync;
      cnt    <= pos_cur;
      a_d    <= own_c & dat_c;
      a_oe   <= own_c | ~fill_hiz;
      a_last <= own_c & fill_hiz & ~own_n;
      a_hold <= a_last;
      c_last <= b_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTR; i++) snap[i] <= '0;
    end else if (fs_start) begin
      for (int i = 0; i < NSTR; i++) snap[i] <= live[i];
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_d    <= 1'b0;
      b_oe   <= 1'b0;
      b_last <= 1'b0;
      b_hold <= 1'b0;
    end else begin
      b_d    <= a_d;
      b_oe   <= a_oe;
      b_last <= a_last;
      b_hold <= a_hold;
    end
  end

  logic l_d, l_oe, l_last, l_hold, o_last, cut;

  assign l_d    = tx_fall ? b_d    : a_d;
  assign l_oe   = tx_fall ? b_oe   : a_oe;
  assign l_last = tx_fall ? b_last : a_last;
  assign l_hold = tx_fall ? b_hold : a_hold;
  assign o_last = tx_fall ? c_last : b_last;
  assign cut    = keep_half & l_last & o_last;

  assign sd_out  = l_d;
  assign sd_oe   = l_oe & ~cut;
  assign keep_en = keep_on & ~sd_oe & (keep_always | l_hold | cut);

endmodule

// File: rtl/tdm_mon_tx_chk.sv
module tdm_mon_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic fsync,
  input logic fill_hiz,
  input logic keep_on,
  input logic keep_always,
  input logic keep_half,
  input logic sd_out,
  input logic sd_oe,
  input logic keep_en
);
  logic seen;
  logic lsb_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen <= 1'b0;
    else if (fsync) seen <= 1'b1;
  end

  assign lsb_mode = keep_on & ~keep_always & ~keep_half;

  assert_keeper_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !keep_on |-> !keep_en);

  assert_fill_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_hiz && $past(!fill_hiz) && $past(!fill_hiz, 2) && $past(rst_n, 2)) |-> sd_oe);

  assert_keep_one_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lsb_mode && keep_en) |=> (!lsb_mode || !keep_en));

  assert_quiet_before_frame_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !sd_out);
endmodule

bind tdm_mon_tx tdm_mon_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .fill_hiz(fill_hiz),
  .keep_on(keep_on), .keep_always(keep_always), .keep_half(keep_half),
  .sd_out(sd_out), .sd_oe(sd_oe), .keep_en(keep_en)
);

// File: tb/tdm_mon_tx_tb.sv
module tdm_mon_tx_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, fsync = 1'b0;
  logic tx_fall, fill_hiz, keep_on, keep_always, keep_half;
  logic [2:0] tx_offset;
  logic [1:0] sense_mode;
  logic vs_en, is_en, s1_en, s2_en, tp_en, st_en;
  logic [5:0] vs_slot, is_slot, s1_slot, s2_slot, tp_slot, st_slot;
  logic [15:0] vs_val, is_val, s1_val, s2_val;
  logic [7:0] tp_val, st_val;
  logic sd_out, sd_oe, keep_en;

  tdm_mon_tx dut_i (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .tx_fall(tx_fall), .tx_offset(tx_offset),
    .fill_hiz(fill_hiz), .sense_mode(sense_mode), .keep_on(keep_on),
    .keep_always(keep_always), .keep_half(keep_half),
    .vs_en(vs_en), .vs_slot(vs_slot), .vs_val(vs_val),
    .is_en(is_en), .is_slot(is_slot), .is_val(is_val),
    .s1_en(s1_en), .s1_slot(s1_slot), .s1_val(s1_val),
    .s2_en(s2_en), .s2_slot(s2_slot), .s2_val(s2_val),
    .tp_en(tp_en), .tp_slot(tp_slot), .tp_val(tp_val),
    .st_en(st_en), .st_slot(st_slot), .st_val(st_val),
    .sd_out(sd_out), .sd_oe(sd_oe), .keep_en(keep_en)
  );

  int checks = 0, errors = 0;
  string tag = "R14";
  bit run_cmp = 1'b0;
  bit mo [0:1024];
  bit mv [0:1024];
  int m_pos = 1023;
  bit m_fsq = 1'b0;
  bit [4:0] cur_t = '0, prv_t = '0;

  task automatic place(input bit en_i, input int start, input int len_i, input logic [15:0] val);
    if (!en_i) return;
    for (int j = 0; j < len_i; j++) begin
      int p;
      p = start + j;
      if (p <= 1024) begin
        mo[p] = 1'b1;
        mv[p] = val[15-j];
      end
    end
  endtask

  task automatic build_map();
    int ofs, sl, vs_s, is_s;
    for (int k = 0; k <= 1024; k++) begin mo[k] = 1'b0; mv[k] = 1'b0; end
    ofs  = int'(tx_offset);
    sl   = (sense_mode == 2'd1) ? 8 : ((sense_mode == 2'd2) ? 12 : 16);
    vs_s = int'(vs_slot) * 8 + ofs;
    is_s = int'(is_slot) * 8 + ofs;
    if (sense_mode == 2'd2 && is_en && int'(vs_slot) == int'(is_slot) + 1) vs_s += 4;
    if (sense_mode == 2'd2 && vs_en && int'(is_slot) == int'(vs_slot) + 1) is_s += 4;
    place(st_en, int'(st_slot) * 8 + ofs, 8, {st_val, 8'h00});
    place(tp_en, int'(tp_slot) * 8 + ofs, 8, {tp_val, 8'h00});
    place(s2_en, int'(s2_slot) * 8 + ofs, 16, s2_val);
    place(s1_en, int'(s1_slot) * 8 + ofs, 16, s1_val);
    place(is_en, is_s, sl, is_val);
    place(vs_en, vs_s, sl, vs_val);
  endtask

  // cur_t/prv_t bits: {hold, last, oe, data, owned}
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 1023; m_fsq = 1'b0; cur_t = '0; prv_t = '0;
      for (int k = 0; k <= 1024; k++) begin mo[k] = 1'b0; mv[k] = 1'b0; end
    end else begin
      prv_t = cur_t;
      if (fsync && !m_fsq) begin m_pos = 0; build_map(); end
      else if (m_pos != 1023) m_pos++;
      m_fsq = fsync;
      cur_t[0] = mo[m_pos];
      cur_t[1] = mo[m_pos] & mv[m_pos];
      cur_t[2] = mo[m_pos] | !fill_hiz;
      cur_t[3] = mo[m_pos] & fill_hiz & !mo[m_pos+1];
      cur_t[4] = prv_t[3];
    end
  end

  task automatic cmp(input bit ph);
    bit [4:0] t;
    bit cut, e_d, e_oe, e_k;
    if (!rst_n || !run_cmp) return;
    if (!tx_fall) begin
      t = cur_t; cut = ph & keep_half & cur_t[3];
    end else if (ph) begin
      t = cur_t; cut = 1'b0;
    end else begin
      t = prv_t; cut = keep_half & prv_t[3];
    end
    e_d  = t[1];
    e_oe = t[2] & !cut;
    e_k  = keep_on & !e_oe & (keep_always | t[4] | cut);
    checks++;
    if (sd_out !== e_d || sd_oe !== e_oe || keep_en !== e_k) begin
      errors++;
      $display("FAIL %s pos=%0d half=%0d: actual out/oe/keep=%b%b%b expected %b%b%b",
               tag, m_pos, ph, sd_out, sd_oe, keep_en, e_d, e_oe, e_k);
    end
  endtask

  always begin
    @(posedge clk);
    #5 cmp(1'b0);
    #10 cmp(1'b1);
  end

  task automatic new_vals();
    vs_val = 16'($urandom); is_val = 16'($urandom);
    s1_val = 16'($urandom); s2_val = 16'($urandom);
    tp_val = 8'($urandom);  st_val = 8'($urandom);
  endtask

  task automatic defaults();
    tx_fall = 0; tx_offset = 3'd1; fill_hiz = 0; sense_mode = 2'd0;
    keep_on = 0; keep_always = 0; keep_half = 0;
    {vs_en, is_en, s1_en, s2_en, tp_en, st_en} = 6'b111111;
    vs_slot = 0; is_slot = 2; s1_slot = 4; s2_slot = 6; tp_slot = 8; st_slot = 9;
    new_vals();
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; fsync = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (sd_out !== 1'b0 || sd_oe !== 1'b0 || keep_en !== (keep_on & keep_always)) begin
      errors++;
      $display("FAIL R14 reset: actual out/oe/keep=%b%b%b expected 00%b",
               sd_out, sd_oe, keep_en, keep_on & keep_always);
    end
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (6) begin @(posedge clk); #2; end
  endtask

  task automatic run_frames(input int nfr, input int flen, input bit churn);
    for (int f = 0; f < nfr; f++) begin
      if (!churn) new_vals();
      fsync = 1'b1;
      @(posedge clk); #2;
      fsync = 1'b0;
      for (int c = 1; c < flen; c++) begin
        if (churn) new_vals();
        @(posedge clk); #2;
      end
    end
    repeat (4) begin @(posedge clk); #2; end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    defaults(); tag = "R14"; reset_dut(); run_cmp = 1'b1;
    tag = "R1 R3 R6 R14 rise offset1";
    run_frames(3, 96, 0);

    defaults(); tx_fall = 1; tx_offset = 0; tag = "R2 R3 fall offset0";
    reset_dut(); run_frames(3, 96, 0);

    defaults(); sense_mode = 2'd1; is_slot = 1; tag = "R4 narrow sense";
    reset_dut(); run_frames(3, 96, 0);

    defaults(); sense_mode = 2'd2; vs_slot = 3; is_slot = 4; tx_offset = 3;
    tag = "R5 packed, current later"; reset_dut(); run_frames(3, 96, 0);

    defaults(); sense_mode = 2'd2; is_slot = 3; vs_slot = 4; tx_fall = 1; tx_offset = 5;
    tag = "R5 packed, voltage later"; reset_dut(); run_frames(3, 96, 0);

    defaults(); tx_offset = 0; vs_slot = 1; is_slot = 0; s1_slot = 1; s2_slot = 2;
    tp_slot = 2; st_slot = 3; tag = "R7 overlap priority";
    reset_dut(); run_frames(3, 64, 0);

    defaults(); tx_offset = 2; s1_slot = 6; st_slot = 7; tp_slot = 5; fill_hiz = 1;
    keep_on = 1; tag = "R9 frame-end cut"; reset_dut(); run_frames(3, 60, 0);

    defaults(); tag = "R8 capture at frame start";
    reset_dut(); run_frames(3, 96, 1);

    defaults(); fill_hiz = 1; keep_on = 0; keep_always = 1; keep_half = 0;
    is_slot = 3; s1_slot = 6; s2_slot = 9; tp_slot = 12; st_slot = 14;
    tag = "R6 R10 release, keeper off"; reset_dut(); run_frames(2, 128, 0);

    keep_on = 1; keep_always = 0; tag = "R11 one-bit keeper";
    reset_dut(); run_frames(2, 128, 0);

    keep_always = 1; tag = "R12 permanent keeper";
    reset_dut(); run_frames(2, 128, 0);

    keep_always = 0; keep_half = 1; tag = "R13 half bit rise";
    reset_dut(); run_frames(2, 128, 0);

    tx_fall = 1; tag = "R13 half bit fall";
    reset_dut(); run_frames(2, 128, 0);

    keep_on = 0; tag = "R13 R10 half bit, keeper off";
    reset_dut(); run_frames(2, 128, 0);

    run_cmp = 1'b0;
    finish_run();
  end
endmodule